// File: doc/BRIEF.md
# Multiplierless Orientation Quantizer

This block takes the two first-order moments of an image patch, the y-weighted sum and the x-weighted sum, and returns the patch's centroid direction as one of 25 discrete orientation codes. The circle is split into 25 equal sectors of 14.4 degrees. Code k stands for the angle k times 14.4 degrees, measured from the positive x axis toward positive y. A downstream coordinate rotator uses the code to pick its sine and cosine pair. The block computes no arctangent and uses no divider or general multiplier.

Each moment arrives as a sign flag and a 12-bit magnitude. For each of the 25 sector boundaries, the block scales both moments by fixed 11-bit coefficients built from shifts and adds. It then reads the sign of a cross product and turns the resulting ring of half-plane flags into a code. A new moment pair may enter on every clock. Each result leaves exactly five clocks later with its own valid flag.

Top module: `orient_quantizer`

## Requirements
- R1: `vld_o` equals `vld_i` as it was sampled five rising clock edges earlier, and a result leaves on every clock that has a valid sample five edges before.
- R2: Whenever `vld_o` is 1, `idx_o` lies between 0 and 24 inclusive.
- R3: Signed moments are X = (-1 if `mom_x_neg_i` else +1)·`mom_x_mag_i` and Y = (-1 if `mom_y_neg_i` else +1)·`mom_y_mag_i`. For boundary j = 0..24, let c_j = round(1024·cos((j+0.5)·14.4°)) and s_j = round(1024·sin((j+0.5)·14.4°)), and let d_j = c_j·Y - s_j·X. The output code is (j+1) mod 25 for the j where d_j > 0 and d_((j+1) mod 25) <= 0.
- R4: A pair lying exactly on boundary j (d_j = 0) counts as not past that boundary. It therefore resolves to the lower code j, and boundary 24 resolves to 24 rather than wrapping to 0.
- R5: When both magnitudes are zero, the code is 0, whatever the sign flags.
- R6: A sign flag of 1 negates its moment. A zero magnitude with its sign flag set behaves as zero.
- R7: Samples entering on consecutive clocks, with any pattern of `vld_i`, each produce their own independent result with no interaction between them.
- R8: The axis directions give fixed codes: +x gives 0, +y gives 6, -x gives 12 (an exact boundary tie at 180 degrees), and -y gives 19.
- R9: While `rst_ni` is low, `vld_o` and `idx_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input moment pair is valid |
| mom_y_neg_i | input | 1 | Sign of the y-weighted moment, 1 = negative |
| mom_y_mag_i | input | 12 | Magnitude of the y-weighted moment |
| mom_x_neg_i | input | 1 | Sign of the x-weighted moment, 1 = negative |
| mom_x_mag_i | input | 12 | Magnitude of the x-weighted moment |
| vld_o | output | 1 | Output code is valid |
| idx_o | output | 5 | Orientation code, 0 to 24 |

## Verification
Two functions can fall on the same sample: the tie rule for a pair sitting exactly on a boundary, and the wrap of the code ring from 24 back to 0. The bench provokes this by driving the pair (c_24, s_24), which lies on the boundary between codes 24 and 0, and the pair (c_j, s_j) for every other j. These pairs are sent back to back with zero pairs and axis pairs, so that several cases are in the pipe at once. A behavioural reference model keeps a queue of expected codes, one entry per clock. The bench compares the outputs against the head of that queue on every clock, judging whether each tie went to the lower code and whether the wrap stayed at 24 instead of turning to 0.

// File: rtl/oq_pkg.sv
package oq_pkg;

  localparam real OQ_PI = 3.14159265358979323846;

  function automatic real oq_sin(real a);
    real x, term, sum;
    x = a;
    while (x > OQ_PI) x = x - 2.0 * OQ_PI;
    while (x < -OQ_PI) x = x + 2.0 * OQ_PI;
    term = x;
    sum  = x;
    for (int n = 1; n < 24; n++) begin
      term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  function automatic real bound_angle(int j, int n);
    return 2.0 * OQ_PI * (real'(j) + 0.5) / real'(n);
  endfunction

  // Rounded fixed-point boundary coefficients, scale 2**frac
  function automatic int coef_cos(int j, int n, int frac);
    return int'(oq_sin(bound_angle(j, n) + OQ_PI / 2.0) * real'(1 << frac));
  endfunction

  function automatic int coef_sin(int j, int n, int frac);
    return int'(oq_sin(bound_angle(j, n)) * real'(1 << frac));
  endfunction

endpackage

// File: rtl/oq_shift_add.sv
module oq_shift_add #(
  parameter int unsigned K     = 1,
  parameter int          K_W   = 11,
  parameter int          IN_W  = 13,
  parameter int          OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  a_i,
  output logic signed [OUT_W-1:0] p_o
);

  logic signed [OUT_W-1:0] a_ext;
  logic signed [OUT_W-1:0] part [K_W+1];

  assign a_ext   = {{(OUT_W-IN_W){a_i[IN_W-1]}}, a_i};
  assign part[0] = '0;

  for (genvar b = 0; b < K_W; b++) begin : g_bit
    if (K[b]) begin : g_add
      assign part[b+1] = part[b] + (a_ext <<< b);
    end else begin : g_skip
      assign part[b+1] = part[b];
    end
  end

  assign p_o = part[K_W];

endmodule

// File: rtl/oq_boundary.sv
module oq_boundary #(
  parameter int J      = 0,
  parameter int N      = 25,
  parameter int FRAC   = 10,
  parameter int IN_W   = 13,
  parameter int PROD_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic signed [IN_W-1:0]  y_i,
  output logic                    past_o
);

  localparam int          COEF_W = FRAC + 1;
  localparam int          CJ     = oq_pkg::coef_cos(J, N, FRAC);
  localparam int          SJ     = oq_pkg::coef_sin(J, N, FRAC);
  localparam int unsigned CJ_ABS = (CJ < 0) ? -CJ : CJ;
  localparam int unsigned SJ_ABS = (SJ < 0) ? -SJ : SJ;

  logic signed [PROD_W-1:0] cy_mag, sx_mag, cy, sx;
  logic signed [PROD_W-1:0] cy_q, sx_q;
  logic signed [PROD_W:0]   diff;

  oq_shift_add #(.K(CJ_ABS), .K_W(COEF_W), .IN_W(IN_W), .OUT_W(PROD_W)) u_mul_c (
    .a_i(y_i), .p_o(cy_mag)
  );
  oq_shift_add #(.K(SJ_ABS), .K_W(COEF_W), .IN_W(IN_W), .OUT_W(PROD_W)) u_mul_s (
    .a_i(x_i), .p_o(sx_mag)
  );

  if (CJ < 0) begin : g_cneg
    assign cy = -cy_mag;
  end else begin : g_cpos
    assign cy = cy_mag;
  end

  if (SJ < 0) begin : g_sneg
    assign sx = -sx_mag;
  end else begin : g_spos
    assign sx = sx_mag;
  end

  // Stage 2: scaled products
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cy_q <= '0;
      sx_q <= '0;
    end else begin
      cy_q <= cy;
      sx_q <= sx;
    end
  end

  assign diff = {cy_q[PROD_W-1], cy_q} - {sx_q[PROD_W-1], sx_q};

  // Stage 3: strictly counter-clockwise of boundary; tie counts as not past
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_o <= 1'b0;
    else         past_o <= (diff > 0);
  end

endmodule

// File: rtl/oq_sector_enc.sv
module oq_sector_enc #(
  parameter int N     = 25,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     past_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [N-1:0]     trans, trans_q;
  logic [IDX_W-1:0] idx_d;

  // Edge of the half-plane ring: past boundary j, not past boundary j+1
  always_comb begin
    for (int j = 0; j < N; j++) begin
      trans[j] = past_i[j] & ~past_i[(j+1) % N];
    end
  end

  // Stage 4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trans_q <= '0;
    else         trans_q <= trans;
  end

  // Lowest transition wins; none (zero vector) gives 0
  always_comb begin
    idx_d = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (trans_q[j]) idx_d = IDX_W'((j + 1) % N);
    end
  end

  // Stage 5
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_o <= '0;
    else         idx_o <= idx_d;
  end

endmodule

// File: rtl/orient_quantizer.sv
module orient_quantizer #(
  parameter int MAG_W  = 12,
  parameter int FRAC   = 10,
  parameter int N_SECT = 25
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vld_i,
  input  logic                      mom_y_neg_i,
  input  logic [MAG_W-1:0]          mom_y_mag_i,
  input  logic                      mom_x_neg_i,
  input  logic [MAG_W-1:0]          mom_x_mag_i,
  output logic                      vld_o,
  output logic [$clog2(N_SECT)-1:0] idx_o
);

  localparam int IDX_W  = $clog2(N_SECT);
  localparam int IN_W   = MAG_W + 1;
  localparam int PROD_W = IN_W + FRAC + 1;
  localparam int LAT    = 5;

  logic signed [IN_W-1:0] x_d, y_d, x_q, y_q;
  logic [N_SECT-1:0]      past;
  logic [LAT-1:0]         vld_sr;

  assign x_d = mom_x_neg_i ? -$signed({1'b0, mom_x_mag_i}) : $signed({1'b0, mom_x_mag_i});
  assign y_d = mom_y_neg_i ? -$signed({1'b0, mom_y_mag_i}) : $signed({1'b0, mom_y_mag_i});

  // Stage 1: signed moments
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  for (genvar j = 0; j < N_SECT; j++) begin : g_bnd
    oq_boundary #(
      .J(j), .N(N_SECT), .FRAC(FRAC), .IN_W(IN_W), .PROD_W(PROD_W)
    ) u_bnd (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .x_i   (x_q),
      .y_i   (y_q),
      .past_o(past[j])
    );
  end

  oq_sector_enc #(.N(N_SECT), .IDX_W(IDX_W)) u_enc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .past_i(past),
    .idx_o (idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_sr <= '0;
    else         vld_sr <= {vld_sr[LAT-2:0], vld_i};
  end

  assign vld_o = vld_sr[LAT-1];

endmodule

// File: rtl/orient_quantizer_chk.sv
module orient_quantizer_chk #(
  parameter int MAG_W  = 12,
  parameter int N_SECT = 25
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      vld_i,
  input logic                      mom_y_neg_i,
  input logic [MAG_W-1:0]          mom_y_mag_i,
  input logic                      mom_x_neg_i,
  input logic [MAG_W-1:0]          mom_x_mag_i,
  input logic                      vld_o,
  input logic [$clog2(N_SECT)-1:0] idx_o
);

  logic [2:0] cnt;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt <= '0;
    else if (cnt != 5) cnt <= cnt + 3'd1;
  end

  assign warm = (cnt == 3'd5);

  // R1
  a_r1_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (vld_o == $past(vld_i, 5)));

  // R2
  a_r2_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (32'(idx_o) < N_SECT));

  // R5
  a_r5_zero_moment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(vld_i && mom_x_mag_i == '0 && mom_y_mag_i == '0, 5)) |-> (idx_o == '0));

  // R8
  a_r8_pos_x_axis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(vld_i && mom_y_mag_i == '0 && mom_x_mag_i != '0 && !mom_x_neg_i, 5))
      |-> (idx_o == 5'd0));

  // R8, R4
  a_r8_neg_x_axis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(vld_i && mom_y_mag_i == '0 && mom_x_mag_i != '0 && mom_x_neg_i, 5))
      |-> (idx_o == 5'd12));

  // R9
  a_r9_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!vld_o && idx_o == '0));

endmodule

bind orient_quantizer orient_quantizer_chk #(.MAG_W(MAG_W), .N_SECT(N_SECT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vld_i      (vld_i),
  .mom_y_neg_i(mom_y_neg_i),
  .mom_y_mag_i(mom_y_mag_i),
  .mom_x_neg_i(mom_x_neg_i),
  .mom_x_mag_i(mom_x_mag_i),
  .vld_o      (vld_o),
  .idx_o      (idx_o)
);

// File: tb/orient_quantizer_bench.sv
module orient_quantizer_bench;

  localparam int  CLK_PERIOD = 10;
  localparam int  NS         = 25;
  localparam real PI         = 3.14159265358979323846;

  typedef struct {
    bit    v;
    int    idx;
    string tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0;
  logic        mom_y_neg_i = 1'b0;
  logic [11:0] mom_y_mag_i = '0;
  logic        mom_x_neg_i = 1'b0;
  logic [11:0] mom_x_mag_i = '0;
  logic        vld_o;
  logic [4:0]  idx_o;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  exp_t q[$];
  int   cc[NS];
  int   ss[NS];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  orient_quantizer u_orient_quantizer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (vld_i),
    .mom_y_neg_i(mom_y_neg_i),
    .mom_y_mag_i(mom_y_mag_i),
    .mom_x_neg_i(mom_x_neg_i),
    .mom_x_mag_i(mom_x_mag_i),
    .vld_o      (vld_o),
    .idx_o      (idx_o)
  );

  // Reference: boundary test of R3 with R4 tie rule and R5 default
  function automatic int ref_idx(int x, int y);
    longint d[NS];
    int     k = 0;
    for (int j = 0; j < NS; j++) d[j] = longint'(cc[j]) * y - longint'(ss[j]) * x;
    for (int j = 0; j < NS; j++) begin
      if (d[j] > 0 && d[(j+1) % NS] <= 0) begin
        k = (j + 1) % NS;
        break;
      end
    end
    return k;
  endfunction

  task automatic check_out();
    exp_t e;
    e = q.pop_front();
    n_chk++;
    if (vld_o !== e.v || (e.v && int'(idx_o) != e.idx))
      begin
        n_fail++;
        $display("FAIL %s: vld_o=%0d idx_o=%0d expected vld=%0d idx=%0d",
                 e.tag, vld_o, idx_o, e.v, e.idx);
      end
  endtask

  task automatic drive_raw(bit v, bit yn, int ym, bit xn, int xm, string tag);
    exp_t e;
    int x, y;
    @(negedge clk_i);
    check_out();
    vld_i       = v;
    mom_y_neg_i = yn;
    mom_y_mag_i = 12'(ym);
    mom_x_neg_i = xn;
    mom_x_mag_i = 12'(xm);
    x = xn ? -xm : xm;
    y = yn ? -ym : ym;
    e.v   = v;
    e.idx = ref_idx(x, y);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(bit v, int x, int y, string tag);
    drive_raw(v, y < 0, (y < 0) ? -y : y, x < 0, (x < 0) ? -x : x, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t e;
    for (int j = 0; j < NS; j++) begin
      cc[j] = int'($cos(2.0 * PI * (real'(j) + 0.5) / NS) * 1024.0);
      ss[j] = int'($sin(2.0 * PI * (real'(j) + 0.5) / NS) * 1024.0);
    end

    // R9: reset state
    repeat (3) @(negedge clk_i);
    vld_i = 1'b1;
    mom_x_mag_i = 12'd100;
    @(negedge clk_i);
    n_chk++;
    if (vld_o !== 1'b0 || idx_o !== 5'd0) begin
      n_fail++;
      $display("FAIL R9: vld_o=%0d idx_o=%0d expected vld=0 idx=0", vld_o, idx_o);
    end
    vld_i = 1'b0;
    mom_x_mag_i = '0;
    rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) begin
      e.v = 1'b0; e.idx = 0; e.tag = "R1";
      q.push_back(e);
    end

    // R8: axes
    drive(1, 900, 0, "R8");
    drive(1, 0, 900, "R8");
    drive(1, -900, 0, "R8");
    drive(1, 0, -900, "R8");
    drive(1, 4095, 0, "R8");
    drive(1, -1, 0, "R8");

    // R5, R6: zero and signed zero
    drive_raw(1, 0, 0, 0, 0, "R5");
    drive_raw(1, 1, 0, 1, 0, "R5");
    drive_raw(1, 1, 0, 0, 700, "R6");
    drive_raw(1, 0, 300, 1, 0, "R6");
    drive(1, -3000, -1200, "R6");

    // R4: exact ties on every boundary, interleaved with zero and wrap pairs
    for (int j = 0; j < NS; j++) begin
      drive(1, cc[j], ss[j], "R4");
      drive(1, 0, 0, "R5");
    end
    drive(1, cc[24], ss[24], "R4");
    drive(1, cc[0], ss[0], "R4");
    drive(1, 4 * cc[24], 4 * ss[24], "R4");

    // R3: extremes and random sweep
    drive(1, 4095, 4095, "R3");
    drive(1, -4095, 4095, "R3");
    drive(1, -4095, -4095, "R3");
    drive(1, 4095, -4095, "R3");
    drive(1, 4095, -1, "R3");
    for (int i = 0; i < 400; i++) begin
      int x = int'($urandom_range(8190)) - 4095;
      int y = int'($urandom_range(8190)) - 4095;
      drive(1, x, y, "R3");
    end

    // R7, R1, R2: valid gaps and toggling
    for (int i = 0; i < 120; i++) begin
      int x = int'($urandom_range(8190)) - 4095;
      int y = int'($urandom_range(8190)) - 4095;
      drive(bit'($urandom_range(1)), x, y, "R7");
    end
    for (int i = 0; i < 20; i++) drive(bit'(i % 2), 50 * i - 500, 400 - 30 * i, "R1");

    for (int i = 0; i < 6; i++) drive(0, 0, 0, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule